// File: doc/BRIEF.md
# Flash Protection Window Checker

This block decides whether a program or erase command aimed at a 32 KB flash region may go ahead. The region spans global addresses 0x7F_8000 to 0x7F_FFFF. An 8-bit protection control value defines two address windows. One window sits against the top of the region and one against the bottom. A polarity bit sets whether the enabled windows are the protected ranges or the only unprotected ranges. During reset, the control value is copied from a nonvolatile configuration byte (kept at global address 0x7F_FF0D and presented on `nv_cfg`). Software may rewrite the value later, under restricted rules.

Each command arrives as a one-cycle strobe that carries a command type and a 23-bit global address. A command that is allowed produces a one-cycle accept pulse. A refused command sets a sticky violation flag. While the flag is set, every later command is refused until software clears the flag by writing a 1.

A three-state controller sequences the block. LOAD is entered on reset; the control value is captured there and commands are ignored. READY is where commands are judged. LOCKED is entered when a violation is found. The controller has three transitions: LOAD to READY always happens on the first clock after reset. READY to LOCKED happens on a refused command. LOCKED to READY happens when the flag is cleared.

Top module: `flash_prot_window`

## Requirements
- R1: While `rst` is high, the control value is loaded from `nv_cfg` with bit 6 forced to 1, `viol_flag` and `cmd_accept` are 0, and the controller is in LOAD. It moves to READY on the first clock edge after `rst` falls.
- R2: The control value has bit 7 = polarity, bit 5 = upper-window disable, bits 4:3 = upper size, bit 2 = lower-window disable, and bits 1:0 = lower size. With polarity 1, an address inside an enabled window is protected, and every other address in the region is unprotected.
- R3: With polarity 0, an address inside an enabled window is unprotected, and every other address in the region is protected.
- R4: The upper window ends at 0x7F_FFFF. Its size is 2 KB, 4 KB, 8 KB or 16 KB for size codes 00, 01, 10 and 11.
- R5: The lower window starts at 0x7F_8000. Its size is 512 B, 1 KB, 2 KB or 4 KB for size codes 00, 01, 10 and 11.
- R6: A window whose disable bit is 1 covers no address, whatever its size code.
- R7: A write (`wr_en`) always updates bits 7, 5 and 2. A size field takes the written value only if its own disable bit was 1 before the write; otherwise the size field keeps its value.
- R8: Bit 6 always reads 1. Writes to bit 6 are ignored, and the bit has no effect on protection.
- R9: Command types are 00 program, 01 sector erase, 10 mass erase and 11 no operation. Program and sector erase check the address given. When a command strobed in READY is allowed, `cmd_accept` is high for exactly the one cycle after the strobe. When the command is refused, `viol_flag` is high from that cycle on.
- R10: A mass erase ignores the address. It is refused if any address in the region is protected. With polarity 0 it is therefore always refused.
- R11: `viol_flag` stays set until a cycle with `viol_clr` high. While the flag is set, no command is accepted.
- R12: An address whose upper 8 bits are not 0xFF lies outside the region and is unprotected under every control value.
- R13: A no-operation command, and any command strobed while in LOAD, produces neither an accept nor a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nv_cfg | input | 8 | Nonvolatile configuration byte, captured during reset |
| wr_en | input | 1 | Software write strobe for the control value |
| wr_data | input | 8 | Data for a control-value write |
| viol_clr | input | 1 | Write-1 strobe that clears the violation flag |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 2 | Command type: 00 program, 01 sector erase, 10 mass erase, 11 none |
| cmd_addr | input | 23 | Global target address of the command |
| prot_q | output | 8 | Current control value |
| cmd_accept | output | 1 | One-cycle pulse for an allowed command |
| viol_flag | output | 1 | Sticky protection-violation flag |

## Verification
The bench probes each window boundary on both sides, for every size code and both polarities. An off-by-one compare or a wrong shift would let the first protected byte through or refuse the last free one. Mass erase is tried with both windows disabled under polarity 1 and under polarity 0. A design that checks the address instead of the whole region would accept erases it must refuse. Size-field writes are tried with the disable bit clear and then set, which catches a design that tests the new disable bit rather than the old one or that lets bit 6 change. The bench also strobes commands while the flag is set, during LOAD and with the no-operation code. A design that re-arms too early, or that counts a no-operation as a fault, would produce a stray accept or a stray flag.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    typedef enum logic [1:0] {
        CMD_PROG = 2'b00,
        CMD_SECT = 2'b01,
        CMD_MASS = 2'b10,
        CMD_NONE = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'b00,
        ST_READY  = 2'b01,
        ST_LOCKED = 2'b10
    } state_e;

    // Field positions are decoded by the judge and read back by software.
    typedef struct packed {
        logic       pol;     // 7: 1 = windows protected, 0 = windows free
        logic       rsv;     // 6: reserved, always 1
        logic       up_off;  // 5: upper window disable
        logic [1:0] up_sz;   // 4:3 upper window size code
        logic       lo_off;  // 2: lower window disable
        logic [1:0] lo_sz;   // 1:0 lower window size code
    } prot_t;

endpackage

// File: rtl/fpw_prot_reg.sv
module fpw_prot_reg
    import fpw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  prot_t nv_cfg,
    input  logic  wr_en,
    input  prot_t wr_data,
    output prot_t q
);

    logic unused_rsv;
    assign unused_rsv = nv_cfg.rsv ^ wr_data.rsv;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= nv_cfg;
            q.rsv <= 1'b1;
        end else if (wr_en) begin
            q.pol    <= wr_data.pol;
            q.rsv    <= 1'b1;
            q.up_off <= wr_data.up_off;
            q.lo_off <= wr_data.lo_off;
            if (q.up_off) q.up_sz <= wr_data.up_sz;
            if (q.lo_off) q.lo_sz <= wr_data.lo_sz;
        end
    end

    // R7: a size field may only move while its window was disabled
    p_up_size_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !q.up_off |=> q.up_sz == $past(q.up_sz));
    p_lo_size_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !q.lo_off |=> q.lo_sz == $past(q.lo_sz));

endmodule

// File: rtl/fpw_window.sv
module fpw_window #(
    parameter int REGION_LOG2 = 15,
    parameter int MIN_LOG2    = 11,
    parameter bit AT_TOP      = 1'b1
) (
    input  logic                   enable,
    input  logic [1:0]             size_sel,
    input  logic [REGION_LOG2-1:0] offset,
    output logic                   hit,
    output logic [REGION_LOG2:0]   span
);

    localparam logic [REGION_LOG2:0] REGION_SIZE = {1'b1, {REGION_LOG2{1'b0}}};
    localparam logic [REGION_LOG2:0] ONE         = {{REGION_LOG2{1'b0}}, 1'b1};

    assign span = ONE << (MIN_LOG2 + int'(size_sel));

    generate
        if (AT_TOP) begin : g_top
            assign hit = enable && ({1'b0, offset} >= (REGION_SIZE - span));
        end else begin : g_bottom
            assign hit = enable && ({1'b0, offset} < span);
        end
    endgenerate

endmodule

// File: rtl/fpw_judge.sv
module fpw_judge
    import fpw_pkg::*;
#(
    parameter int              ADDR_W      = 23,
    parameter int              REGION_LOG2 = 15,
    parameter int              UP_MIN_LOG2 = 11,
    parameter int              LO_MIN_LOG2 = 9,
    parameter logic [ADDR_W-REGION_LOG2-1:0] REGION_TAG = '1
) (
    input  logic              pol,
    input  logic              up_off,
    input  logic [1:0]        up_sz,
    input  logic              lo_off,
    input  logic [1:0]        lo_sz,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region,
    output logic              allow,
    output logic              viol
);

    localparam int SUM_W = REGION_LOG2 + 2;
    localparam logic [SUM_W-1:0] REGION_SIZE = {2'b01, {REGION_LOG2{1'b0}}};

    logic [REGION_LOG2-1:0] offset;
    logic                   up_hit, lo_hit;
    logic [REGION_LOG2:0]   up_span, lo_span;
    logic [SUM_W-1:0]       covered;
    logic                   addr_prot, any_prot;

    assign offset    = addr[REGION_LOG2-1:0];
    assign in_region = (addr[ADDR_W-1:REGION_LOG2] == REGION_TAG);

    fpw_window #(.REGION_LOG2(REGION_LOG2), .MIN_LOG2(UP_MIN_LOG2), .AT_TOP(1'b1)) u_up (
        .enable(!up_off), .size_sel(up_sz), .offset(offset), .hit(up_hit), .span(up_span));

    fpw_window #(.REGION_LOG2(REGION_LOG2), .MIN_LOG2(LO_MIN_LOG2), .AT_TOP(1'b0)) u_lo (
        .enable(!lo_off), .size_sel(lo_sz), .offset(offset), .hit(lo_hit), .span(lo_span));

    // Bytes covered by enabled windows (they never overlap at these sizes).
    assign covered = (up_off ? '0 : {1'b0, up_span}) + (lo_off ? '0 : {1'b0, lo_span});

    always_comb begin
        addr_prot = in_region && (pol ? (up_hit || lo_hit) : !(up_hit || lo_hit));
        any_prot  = pol ? (!up_off || !lo_off) : (covered < REGION_SIZE);
        unique case (cmd)
            CMD_PROG, CMD_SECT: viol = addr_prot;
            CMD_MASS:           viol = any_prot;
            default:            viol = 1'b0;
        endcase
        allow = (cmd != CMD_NONE) && !viol;
    end

endmodule

// File: rtl/flash_prot_window.sv
module flash_prot_window
    import fpw_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int REGION_LOG2 = 15,
    parameter int UP_MIN_LOG2 = 11,
    parameter int LO_MIN_LOG2 = 9,
    parameter int CFG_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  nv_cfg,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              viol_clr,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic [CFG_W-1:0]  prot_q,
    output logic              cmd_accept,
    output logic              viol_flag
);

    localparam int TAG_W = ADDR_W - REGION_LOG2;

    state_e state, state_nxt;
    prot_t  cfg;
    cmd_e   cmd;
    logic   in_region, allow, viol;

    assign cmd    = cmd_e'(cmd_type);
    assign prot_q = cfg;

    fpw_prot_reg u_reg (
        .clk(clk), .rst(rst), .nv_cfg(prot_t'(nv_cfg)),
        .wr_en(wr_en), .wr_data(prot_t'(wr_data)), .q(cfg));

    fpw_judge #(
        .ADDR_W(ADDR_W), .REGION_LOG2(REGION_LOG2),
        .UP_MIN_LOG2(UP_MIN_LOG2), .LO_MIN_LOG2(LO_MIN_LOG2),
        .REGION_TAG({TAG_W{1'b1}})
    ) u_judge (
        .pol(cfg.pol), .up_off(cfg.up_off), .up_sz(cfg.up_sz),
        .lo_off(cfg.lo_off), .lo_sz(cfg.lo_sz),
        .cmd(cmd), .addr(cmd_addr),
        .in_region(in_region), .allow(allow), .viol(viol));

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOAD;
        else     state <= state_nxt;
    end

    // Transitions: LOAD->READY, READY->LOCKED on fault, LOCKED->READY on clear
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOAD:   state_nxt = ST_READY;
            ST_READY:  if (cmd_valid && viol) state_nxt = ST_LOCKED;
            ST_LOCKED: if (viol_clr) state_nxt = ST_READY;
            default:   state_nxt = ST_LOAD;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) cmd_accept <= 1'b0;
        else     cmd_accept <= (state == ST_READY) && cmd_valid && allow;
    end

    assign viol_flag = (state == ST_LOCKED);

    // R9: an accept always answers a strobe of the previous cycle
    p_accept_follows_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> $past(cmd_valid));
    // R9: an accepted command never raises the flag
    p_accept_excl_flag_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> !viol_flag);
    // R11: flag holds until cleared
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !viol_clr) |=> viol_flag);
    // R11: nothing is accepted while locked
    p_no_accept_locked_r11: assert property (@(posedge clk) disable iff (rst)
        viol_flag |=> !cmd_accept);
    // R10: mass erase under polarity 0 is refused
    p_mass_pol0_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && cmd_valid && cmd == CMD_MASS && !cfg.pol) |=> (!cmd_accept && viol_flag));
    // R12: targets outside the region pass
    p_outside_free_r12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && cmd_valid && !in_region && (cmd == CMD_PROG || cmd == CMD_SECT))
        |=> cmd_accept);
    // R13: strobes during LOAD do nothing
    p_load_ignored_r13: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |=> (!cmd_accept && !viol_flag));

endmodule

// File: tb/flash_prot_window_test.sv
`timescale 1ns/1ps
module flash_prot_window_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  nv_cfg = 8'hE4;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        viol_clr = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'b00;
    logic [22:0] cmd_addr = '0;
    logic [7:0]  prot_q;
    logic        cmd_accept, viol_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_prot_window uut (
        .clk(clk), .rst(rst), .nv_cfg(nv_cfg), .wr_en(wr_en), .wr_data(wr_data),
        .viol_clr(viol_clr), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_addr(cmd_addr), .prot_q(prot_q), .cmd_accept(cmd_accept), .viol_flag(viol_flag));

    // {cfg, type, addr, expect accept}; type 0 prog, 1 sector, 2 mass
    localparam int NV = 36;
    localparam logic [33:0] VEC [NV] = '{
        {8'hE4, 2'd0, 23'h7FFFFF, 1'b1},  // R6 both windows off, pol 1
        {8'hE4, 2'd0, 23'h7F8000, 1'b1},  // R6
        {8'hE4, 2'd2, 23'h000000, 1'b1},  // R10 nothing protected
        {8'hC4, 2'd0, 23'h7FF800, 1'b0},  // R2 R4 upper 2K
        {8'hC4, 2'd0, 23'h7FF7FF, 1'b1},  // R4
        {8'hC4, 2'd0, 23'h7F8000, 1'b1},  // R6 lower off
        {8'hC4, 2'd2, 23'h7F8000, 1'b0},  // R10
        {8'hCC, 2'd0, 23'h7FF000, 1'b0},  // R4 4K
        {8'hCC, 2'd1, 23'h7FEFFF, 1'b1},  // R4
        {8'hD4, 2'd0, 23'h7FE000, 1'b0},  // R4 8K
        {8'hD4, 2'd0, 23'h7FDFFF, 1'b1},  // R4
        {8'hDC, 2'd1, 23'h7FC000, 1'b0},  // R4 16K
        {8'hDC, 2'd0, 23'h7FBFFF, 1'b1},  // R4
        {8'hE0, 2'd0, 23'h7F81FF, 1'b0},  // R5 512B
        {8'hE0, 2'd0, 23'h7F8200, 1'b1},  // R5
        {8'hE1, 2'd0, 23'h7F83FF, 1'b0},  // R5 1K
        {8'hE1, 2'd0, 23'h7F8400, 1'b1},  // R5
        {8'hE2, 2'd1, 23'h7F87FF, 1'b0},  // R5 2K
        {8'hE2, 2'd0, 23'h7F8800, 1'b1},  // R5
        {8'hE3, 2'd0, 23'h7F8FFF, 1'b0},  // R5 4K
        {8'hE3, 2'd0, 23'h7F9000, 1'b1},  // R5
        {8'h64, 2'd0, 23'h7F9000, 1'b0},  // R3 pol 0, no window
        {8'h64, 2'd0, 23'h7F7FFF, 1'b1},  // R12
        {8'h64, 2'd2, 23'h7F8000, 1'b0},  // R10
        {8'h44, 2'd0, 23'h7FF800, 1'b1},  // R3 upper free
        {8'h44, 2'd0, 23'h7FF7FF, 1'b0},  // R3
        {8'h44, 2'd1, 23'h7FFFFF, 1'b1},  // R3
        {8'h40, 2'd0, 23'h7F81FF, 1'b1},  // R3 lower free
        {8'h40, 2'd0, 23'h7F8200, 1'b0},  // R3
        {8'h40, 2'd2, 23'h000000, 1'b0},  // R10 pol 0 always refused
        {8'h5C, 2'd0, 23'h7FC000, 1'b1},  // R3 upper 16K free
        {8'h5C, 2'd0, 23'h7FBFFF, 1'b0},  // R3
        {8'hC0, 2'd0, 23'h000000, 1'b1},  // R12
        {8'hC0, 2'd0, 23'h7F7FFF, 1'b1},  // R12
        {8'hC0, 2'd0, 23'h7F8000, 1'b0},  // R2 lower protected
        {8'h84, 2'd0, 23'h7FF800, 1'b0}   // R8 bit 6 clear in cfg, same protection
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge with the controller in READY.
    task automatic do_reset(input logic [7:0] cfg);
        rst = 1'b1;
        nv_cfg = cfg;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] t, input logic [22:0] a);
        cmd_valid = 1'b1;
        cmd_type = t;
        cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);

        // R1 reset state and R8 bit 6 forced
        do_reset(8'h84);
        chk("R1 prot_q", {24'd0, prot_q}, 32'hC4);
        chk("R1 viol_flag", {31'd0, viol_flag}, 32'd0);
        chk("R1 cmd_accept", {31'd0, cmd_accept}, 32'd0);

        // Vector table: R2..R6, R8, R10, R12
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC[i][33:26]);
            issue(VEC[i][25:24], VEC[i][23:1]);
            chk($sformatf("R9 vec %0d accept", i), {31'd0, cmd_accept}, {31'd0, VEC[i][0]});
            chk($sformatf("R9 vec %0d flag", i), {31'd0, viol_flag}, {31'd0, !VEC[i][0]});
        end

        // R7 / R8 write rules, starting from 0xC4
        do_reset(8'hC4);
        write_reg(8'h1B);
        chk("R7 R8 upper size locked, lower size open", {24'd0, prot_q}, 32'h43);
        write_reg(8'h38);
        chk("R7 upper disable set, sizes held", {24'd0, prot_q}, 32'h63);
        write_reg(8'h38);
        chk("R7 upper size written while disabled", {24'd0, prot_q}, 32'h7B);

        // R11 sticky flag, clear, and R9 pulse width
        do_reset(8'hC4);
        issue(2'd0, 23'h7FF800);
        chk("R11 flag set", {31'd0, viol_flag}, 32'd1);
        issue(2'd0, 23'h7F8000);
        chk("R11 allowed cmd refused while locked", {31'd0, cmd_accept}, 32'd0);
        chk("R11 flag held", {31'd0, viol_flag}, 32'd1);
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
        chk("R11 flag cleared", {31'd0, viol_flag}, 32'd0);
        issue(2'd0, 23'h7F8000);
        chk("R11 accept after clear", {31'd0, cmd_accept}, 32'd1);
        @(negedge clk);
        chk("R9 accept one cycle", {31'd0, cmd_accept}, 32'd0);

        // R13 no-operation code
        issue(2'd3, 23'h7FF800);
        chk("R13 nop accept", {31'd0, cmd_accept}, 32'd0);
        chk("R13 nop flag", {31'd0, viol_flag}, 32'd0);

        // R13 strobe during LOAD
        rst = 1'b1;
        nv_cfg = 8'hE4;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        issue(2'd0, 23'h7F8000);
        chk("R13 load accept", {31'd0, cmd_accept}, 32'd0);
        chk("R13 load flag", {31'd0, viol_flag}, 32'd0);
        issue(2'd0, 23'h7F8000);
        chk("R1 ready after load", {31'd0, cmd_accept}, 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule